// File: doc/BRIEF.md
# Per-Link Signaling Code Store with Source Selection

This block keeps the four-bit channel signaling codes for a group of independent links, 32 channel entries per link. Each entry holds bits D, C, B and A, from bit 3 down to bit 0. A per-link source field picks which of three update paths may change that link's entries. The first path is a strobed update port fed by the receive line side. The second is a strobed update port fed by the VT mapper. The third is the host register write port. Updates that arrive from a source that is not selected for the target link are dropped.

The stored codes are always visible on three independent read ports: one for the transmit system side, one for the transmit line side and one for host readback. Each read port is addressed by link and channel and returns the entry without a clock of delay.

An optional debounce filter holds back line and mapper codes until the same value has arrived twice in a row for a channel. When a link moves from an incoming source to host mode, its codes freeze in place. Host mode is meant to be used only with debounce on, so entering host mode while debounce is off sets a sticky error flag.

Top module: `sigsel_top`

## Requirements
- R1: After reset every entry reads 0, every link uses source 0 (receive line), debounce is off, and `cfg_err` is 0.
- R2: Entries are addressed by link and by channel 0..31. Each holds a 4-bit code with D at bit 3 and A at bit 0, and a write to one channel leaves the other channels unchanged.
- R3: Source encoding is 0 = line, 1 = mapper, 2 = host, 3 = hold. With source 0 and debounce off, a `line_vld` update is readable from the next cycle on.
- R4: With source 1, only `map_vld` updates are stored. Line updates for that link are dropped.
- R5: With source 2, only `host_we` writes change the link's entries, and the written code is stored unchanged. Host writes to a link in source 0 or 1 are dropped.
- R6: Moving a link from source 0 to source 2 keeps every existing code. A host write then changes only its own entry, and returning to source 0 lets line updates store again.
- R7: `cfg_err` goes to 1 in the cycle after a link enters source 2 while debounce is off (taking any debounce write in that same cycle into account), and it stays at 1 until reset.
- R8: Each link applies its own source on its own. A line update, a mapper update and a host write aimed at three links with matching sources all land in the same cycle.
- R9: The transmit system, transmit line and host readback ports each return the addressed entry combinationally.
- R10: With debounce on, a line or mapper code is stored only when it equals the previous accepted update for that channel. Any change of a link's source clears that link's pending history.
- R11: If a host write and a line update hit the same entry in the same cycle, the path allowed by the link's source wins and the other is discarded.
- R12: With source 3, no update path changes the link's entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for a link's source field |
| cfg_link | input | LINK_W | Link whose source is written |
| cfg_src | input | 2 | New source: 0 line, 1 mapper, 2 host, 3 hold |
| dbn_we | input | 1 | Write strobe for the debounce enable |
| dbn_val | input | 1 | New debounce enable value |
| line_vld | input | 1 | Line update strobe |
| line_link | input | LINK_W | Line update link |
| line_ch | input | CH_W | Line update channel |
| line_code | input | CODE_W | Line update code (DCBA) |
| map_vld | input | 1 | Mapper update strobe |
| map_link | input | LINK_W | Mapper update link |
| map_ch | input | CH_W | Mapper update channel |
| map_code | input | CODE_W | Mapper update code |
| host_we | input | 1 | Host entry write strobe |
| host_link | input | LINK_W | Host write link |
| host_ch | input | CH_W | Host write channel |
| host_code | input | CODE_W | Host write code |
| tx_sys_link | input | LINK_W | Transmit system read link |
| tx_sys_ch | input | CH_W | Transmit system read channel |
| tx_sys_code | output | CODE_W | Transmit system read data |
| tx_line_link | input | LINK_W | Transmit line read link |
| tx_line_ch | input | CH_W | Transmit line read channel |
| tx_line_code | output | CODE_W | Transmit line read data |
| host_rd_link | input | LINK_W | Host readback link |
| host_rd_ch | input | CH_W | Host readback channel |
| host_rd_code | output | CODE_W | Host readback data |
| cfg_err | output | 1 | Sticky flag: host mode entered with debounce off |

## Verification
A host write and a line update can hit the same link and channel in the same clock. The bench drives both strobes on one falling edge with different codes. It first does this while the link is in line mode and expects the line code back on all three read ports. It then switches the link to host mode, repeats the collision, and expects the host code. A second same-cycle case sends line, mapper and host traffic to three links with different sources and checks that all three entries land together.

// File: rtl/sigsel_pkg.sv
package sigsel_pkg;

    typedef enum logic [1:0] {
        SRC_LINE = 2'd0,
        SRC_MAP  = 2'd1,
        SRC_HOST = 2'd2,
        SRC_HOLD = 2'd3
    } src_e;

endpackage

// File: rtl/sigsel_cfg.sv
module sigsel_cfg
    import sigsel_pkg::*;
#(
    parameter int NUM_LINKS = 4,
    localparam int LINK_W = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [LINK_W-1:0]     cfg_link,
    input  src_e                  cfg_src,
    input  logic                  dbn_we,
    input  logic                  dbn_val,
    output src_e [NUM_LINKS-1:0]  src_sel,
    output logic                  dbn_en,
    output logic                  cfg_err,
    output logic [NUM_LINKS-1:0]  src_chg
);

    typedef struct packed {
        src_e [NUM_LINKS-1:0] src;
        logic                 dbn;
        logic                 err;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [NUM_LINKS-1:0] chg_d;

    always_comb begin
        cfg_d = cfg_q;
        chg_d = '0;
        if (dbn_we) begin
            cfg_d.dbn = dbn_val;
        end
        for (int l = 0; l < NUM_LINKS; l++) begin
            if (cfg_we && (cfg_link == LINK_W'(l))) begin
                if (cfg_src != cfg_q.src[l]) begin
                    chg_d[l] = 1'b1;
                end
                // entering host mode without the filter on is a setup fault
                if ((cfg_src == SRC_HOST) && (cfg_q.src[l] != SRC_HOST) && !cfg_d.dbn) begin
                    cfg_d.err = 1'b1;
                end
                cfg_d.src[l] = cfg_src;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign src_sel = cfg_q.src;
    assign dbn_en  = cfg_q.dbn;
    assign cfg_err = cfg_q.err;
    assign src_chg = chg_d;

endmodule

// File: rtl/sigsel_take.sv
module sigsel_take
    import sigsel_pkg::*;
#(
    parameter int LINK_IDX = 0,
    parameter int LINK_W   = 2,
    parameter int CH_W     = 5,
    parameter int NUM_CH   = 32
) (
    input  src_e              src,
    input  logic              line_vld,
    input  logic [LINK_W-1:0] line_link,
    input  logic [CH_W-1:0]   line_ch,
    input  logic              map_vld,
    input  logic [LINK_W-1:0] map_link,
    input  logic [CH_W-1:0]   map_ch,
    input  logic              host_we,
    input  logic [LINK_W-1:0] host_link,
    input  logic [CH_W-1:0]   host_ch,
    output logic              take_line,
    output logic              take_map,
    output logic              take_host
);

    logic line_hit, map_hit, host_hit;

    always_comb begin
        line_hit  = line_vld && (line_link == LINK_W'(LINK_IDX)) && (int'(line_ch) < NUM_CH);
        map_hit   = map_vld  && (map_link  == LINK_W'(LINK_IDX)) && (int'(map_ch)  < NUM_CH);
        host_hit  = host_we  && (host_link == LINK_W'(LINK_IDX)) && (int'(host_ch) < NUM_CH);
        take_line = line_hit && (src == SRC_LINE);
        take_map  = map_hit  && (src == SRC_MAP);
        take_host = host_hit && (src == SRC_HOST);
    end

endmodule

// File: rtl/sigsel_store.sv
module sigsel_store
    import sigsel_pkg::*;
#(
    parameter int NUM_LINKS = 4,
    parameter int NUM_CH    = 32,
    parameter int CODE_W    = 4,
    localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          dbn_en,
    input  logic [NUM_LINKS-1:0]                          src_chg,
    input  logic [NUM_LINKS-1:0]                          take_line,
    input  logic [NUM_LINKS-1:0]                          take_map,
    input  logic [NUM_LINKS-1:0]                          take_host,
    input  logic [CH_W-1:0]                               line_ch,
    input  logic [CODE_W-1:0]                             line_code,
    input  logic [CH_W-1:0]                               map_ch,
    input  logic [CODE_W-1:0]                             map_code,
    input  logic [CH_W-1:0]                               host_ch,
    input  logic [CODE_W-1:0]                             host_code,
    output logic [NUM_LINKS-1:0][NUM_CH-1:0][CODE_W-1:0]  ent
);

    typedef struct packed {
        logic [NUM_LINKS-1:0][NUM_CH-1:0][CODE_W-1:0] ent;
        logic [NUM_LINKS-1:0][NUM_CH-1:0][CODE_W-1:0] pend;
        logic [NUM_LINKS-1:0][NUM_CH-1:0]             pv;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        logic             upd;
        logic [CH_W-1:0]  uch;
        logic [CODE_W-1:0] ucode;
        st_d = st_q;
        for (int l = 0; l < NUM_LINKS; l++) begin
            // a link's source admits at most one of line or mapper
            upd   = take_line[l] || take_map[l];
            uch   = take_line[l] ? line_ch   : map_ch;
            ucode = take_line[l] ? line_code : map_code;
            if (upd) begin
                if (!dbn_en || (st_q.pv[l][uch] && (st_q.pend[l][uch] == ucode))) begin
                    st_d.ent[l][uch] = ucode;
                end
                st_d.pend[l][uch] = ucode;
                st_d.pv[l][uch]   = 1'b1;
            end
            if (take_host[l]) begin
                st_d.ent[l][host_ch] = host_code;
            end
            if (src_chg[l]) begin
                st_d.pv[l] = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ent = st_q.ent;

endmodule

// File: rtl/sigsel_top.sv
module sigsel_top
    import sigsel_pkg::*;
#(
    parameter int NUM_LINKS = 4,
    parameter int NUM_CH    = 32,
    parameter int CODE_W    = 4,
    localparam int LINK_W   = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1,
    localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [LINK_W-1:0] cfg_link,
    input  logic [1:0]        cfg_src,
    input  logic              dbn_we,
    input  logic              dbn_val,
    input  logic              line_vld,
    input  logic [LINK_W-1:0] line_link,
    input  logic [CH_W-1:0]   line_ch,
    input  logic [CODE_W-1:0] line_code,
    input  logic              map_vld,
    input  logic [LINK_W-1:0] map_link,
    input  logic [CH_W-1:0]   map_ch,
    input  logic [CODE_W-1:0] map_code,
    input  logic              host_we,
    input  logic [LINK_W-1:0] host_link,
    input  logic [CH_W-1:0]   host_ch,
    input  logic [CODE_W-1:0] host_code,
    input  logic [LINK_W-1:0] tx_sys_link,
    input  logic [CH_W-1:0]   tx_sys_ch,
    output logic [CODE_W-1:0] tx_sys_code,
    input  logic [LINK_W-1:0] tx_line_link,
    input  logic [CH_W-1:0]   tx_line_ch,
    output logic [CODE_W-1:0] tx_line_code,
    input  logic [LINK_W-1:0] host_rd_link,
    input  logic [CH_W-1:0]   host_rd_ch,
    output logic [CODE_W-1:0] host_rd_code,
    output logic              cfg_err
);

    src_e [NUM_LINKS-1:0]                          src_sel;
    logic                                          dbn_en;
    logic [NUM_LINKS-1:0]                          src_chg;
    logic [NUM_LINKS-1:0]                          take_line, take_map, take_host;
    logic [NUM_LINKS-1:0][NUM_CH-1:0][CODE_W-1:0]  ent;

    sigsel_cfg #(.NUM_LINKS(NUM_LINKS)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_link (cfg_link),
        .cfg_src  (src_e'(cfg_src)),
        .dbn_we   (dbn_we),
        .dbn_val  (dbn_val),
        .src_sel  (src_sel),
        .dbn_en   (dbn_en),
        .cfg_err  (cfg_err),
        .src_chg  (src_chg)
    );

    for (genvar g = 0; g < NUM_LINKS; g++) begin : g_take
        sigsel_take #(
            .LINK_IDX (g),
            .LINK_W   (LINK_W),
            .CH_W     (CH_W),
            .NUM_CH   (NUM_CH)
        ) u_take (
            .src       (src_sel[g]),
            .line_vld  (line_vld),
            .line_link (line_link),
            .line_ch   (line_ch),
            .map_vld   (map_vld),
            .map_link  (map_link),
            .map_ch    (map_ch),
            .host_we   (host_we),
            .host_link (host_link),
            .host_ch   (host_ch),
            .take_line (take_line[g]),
            .take_map  (take_map[g]),
            .take_host (take_host[g])
        );
    end

    sigsel_store #(
        .NUM_LINKS (NUM_LINKS),
        .NUM_CH    (NUM_CH),
        .CODE_W    (CODE_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .dbn_en    (dbn_en),
        .src_chg   (src_chg),
        .take_line (take_line),
        .take_map  (take_map),
        .take_host (take_host),
        .line_ch   (line_ch),
        .line_code (line_code),
        .map_ch    (map_ch),
        .map_code  (map_code),
        .host_ch   (host_ch),
        .host_code (host_code),
        .ent       (ent)
    );

    assign tx_sys_code  = ent[tx_sys_link][tx_sys_ch];
    assign tx_line_code = ent[tx_line_link][tx_line_ch];
    assign host_rd_code = ent[host_rd_link][host_rd_ch];

endmodule

// File: rtl/sigsel_chk.sv
module sigsel_chk
    import sigsel_pkg::*;
#(
    parameter int NUM_LINKS = 4,
    parameter int NUM_CH    = 32,
    parameter int CODE_W    = 4,
    localparam int LINK_W   = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1,
    localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input logic                                          clk,
    input logic                                          rst_n,
    input logic                                          cfg_we,
    input logic [LINK_W-1:0]                             cfg_link,
    input logic [1:0]                                    cfg_src,
    input logic                                          dbn_we,
    input logic                                          dbn_val,
    input logic                                          line_vld,
    input logic [LINK_W-1:0]                             line_link,
    input logic [CH_W-1:0]                               line_ch,
    input logic [CODE_W-1:0]                             line_code,
    input logic                                          map_vld,
    input logic [LINK_W-1:0]                             map_link,
    input logic [CH_W-1:0]                               map_ch,
    input logic                                          host_we,
    input logic [LINK_W-1:0]                             host_link,
    input logic [CH_W-1:0]                               host_ch,
    input logic [CODE_W-1:0]                             host_code,
    input logic                                          cfg_err,
    input logic                                          dbn_en,
    input src_e [NUM_LINKS-1:0]                          src_sel,
    input logic [NUM_LINKS-1:0][NUM_CH-1:0][CODE_W-1:0]  ent
);

    logic dbn_next;
    logic line_other_hit;
    assign dbn_next = dbn_we ? dbn_val : dbn_en;
    assign line_other_hit = (map_vld && (map_link == line_link) && (map_ch == line_ch))
                         || (host_we && (host_link == line_link) && (host_ch == line_ch));

    assert_host_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && (src_sel[host_link] == SRC_HOST))
        |=> (ent[$past(host_link)][$past(host_ch)] == $past(host_code)));

    assert_line_direct_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (line_vld && (src_sel[line_link] == SRC_LINE) && !dbn_en)
        |=> (ent[$past(line_link)][$past(line_ch)] == $past(line_code)));

    assert_line_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (line_vld && (src_sel[line_link] != SRC_LINE) && !line_other_hit)
        |=> (ent[$past(line_link)][$past(line_ch)] == $past(ent[line_link][line_ch])));

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    assert_err_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (cfg_src == 2'd2) && (src_sel[cfg_link] != SRC_HOST) && !dbn_next)
        |=> cfg_err);

    for (genvar g = 0; g < NUM_LINKS; g++) begin : g_frz
        assert_host_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ((src_sel[g] == SRC_HOST) && !(host_we && (host_link == LINK_W'(g))))
            |=> $stable(ent[g]));
        assert_hold_mode_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (src_sel[g] == SRC_HOLD) |=> $stable(ent[g]));
    end

endmodule

bind sigsel_top sigsel_chk #(
    .NUM_LINKS (NUM_LINKS),
    .NUM_CH    (NUM_CH),
    .CODE_W    (CODE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_link  (cfg_link),
    .cfg_src   (cfg_src),
    .dbn_we    (dbn_we),
    .dbn_val   (dbn_val),
    .line_vld  (line_vld),
    .line_link (line_link),
    .line_ch   (line_ch),
    .line_code (line_code),
    .map_vld   (map_vld),
    .map_link  (map_link),
    .map_ch    (map_ch),
    .host_we   (host_we),
    .host_link (host_link),
    .host_ch   (host_ch),
    .host_code (host_code),
    .cfg_err   (cfg_err),
    .dbn_en    (dbn_en),
    .src_sel   (src_sel),
    .ent       (ent)
);

// File: tb/sim_sigsel_top.sv
module sim_sigsel_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_link = '0;
    logic [1:0] cfg_src = '0;
    logic       dbn_we = 1'b0;
    logic       dbn_val = 1'b0;
    logic       line_vld = 1'b0;
    logic [1:0] line_link = '0;
    logic [4:0] line_ch = '0;
    logic [3:0] line_code = '0;
    logic       map_vld = 1'b0;
    logic [1:0] map_link = '0;
    logic [4:0] map_ch = '0;
    logic [3:0] map_code = '0;
    logic       host_we = 1'b0;
    logic [1:0] host_link = '0;
    logic [4:0] host_ch = '0;
    logic [3:0] host_code = '0;
    logic [1:0] tx_sys_link = '0, tx_line_link = '0, host_rd_link = '0;
    logic [4:0] tx_sys_ch = '0, tx_line_ch = '0, host_rd_ch = '0;
    logic [3:0] tx_sys_code, tx_line_code, host_rd_code;
    logic       cfg_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sigsel_top u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_link(cfg_link), .cfg_src(cfg_src),
        .dbn_we(dbn_we), .dbn_val(dbn_val),
        .line_vld(line_vld), .line_link(line_link), .line_ch(line_ch), .line_code(line_code),
        .map_vld(map_vld), .map_link(map_link), .map_ch(map_ch), .map_code(map_code),
        .host_we(host_we), .host_link(host_link), .host_ch(host_ch), .host_code(host_code),
        .tx_sys_link(tx_sys_link), .tx_sys_ch(tx_sys_ch), .tx_sys_code(tx_sys_code),
        .tx_line_link(tx_line_link), .tx_line_ch(tx_line_ch), .tx_line_code(tx_line_code),
        .host_rd_link(host_rd_link), .host_rd_ch(host_rd_ch), .host_rd_code(host_rd_code),
        .cfg_err(cfg_err)
    );

    // vector fields: op[17:15] link[14:13] ch[12:8] code[7:4] req[3:0]
    localparam logic [2:0] OP_CFG = 3'd0, OP_LINE = 3'd1, OP_MAP = 3'd2, OP_HOST = 3'd3, OP_CHK = 3'd4;
    localparam int NVEC = 21;
    localparam logic [17:0] VEC [NVEC] = '{
        {OP_LINE, 2'd0, 5'd3,  4'hA, 4'd0},
        {OP_CHK,  2'd0, 5'd3,  4'hA, 4'd3},
        {OP_CFG,  2'd1, 5'd0,  4'h1, 4'd0},
        {OP_MAP,  2'd1, 5'd5,  4'h6, 4'd0},
        {OP_LINE, 2'd1, 5'd5,  4'h9, 4'd0},
        {OP_CHK,  2'd1, 5'd5,  4'h6, 4'd4},
        {OP_CFG,  2'd2, 5'd0,  4'h2, 4'd0},
        {OP_HOST, 2'd2, 5'd31, 4'hF, 4'd0},
        {OP_LINE, 2'd2, 5'd31, 4'h1, 4'd0},
        {OP_MAP,  2'd2, 5'd31, 4'h3, 4'd0},
        {OP_CHK,  2'd2, 5'd31, 4'hF, 4'd5},
        {OP_HOST, 2'd0, 5'd3,  4'h2, 4'd0},
        {OP_CHK,  2'd0, 5'd3,  4'hA, 4'd5},
        {OP_CFG,  2'd3, 5'd0,  4'h3, 4'd0},
        {OP_LINE, 2'd3, 5'd0,  4'h7, 4'd0},
        {OP_CHK,  2'd3, 5'd0,  4'h0, 4'd12},
        {OP_LINE, 2'd0, 5'd30, 4'h8, 4'd0},
        {OP_HOST, 2'd2, 5'd30, 4'h1, 4'd0},
        {OP_CHK,  2'd0, 5'd30, 4'h8, 4'd2},
        {OP_CHK,  2'd0, 5'd31, 4'h0, 4'd2},
        {OP_CHK,  2'd2, 5'd30, 4'h1, 4'd5}
    };

    function automatic string rq(input int n);
        case (n)
            2:  rq = "R2";
            3:  rq = "R3";
            4:  rq = "R4";
            5:  rq = "R5";
            12: rq = "R12";
            default: rq = "R9";
        endcase
    endfunction

    task automatic chk_val(input string req, input string what, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // samples all three read ports; called just after a falling edge
    task automatic chk_ent(input string req, input logic [1:0] l, input logic [4:0] c, input logic [3:0] exp);
        tx_sys_link = l;  tx_sys_ch = c;
        tx_line_link = l; tx_line_ch = c;
        host_rd_link = l; host_rd_ch = c;
        #2;
        chk_val(req, $sformatf("tx_sys L%0d C%0d", l, c), tx_sys_code, exp);
        chk_val("R9", $sformatf("tx_line L%0d C%0d", l, c), tx_line_code, exp);
        chk_val("R9", $sformatf("host_rd L%0d C%0d", l, c), host_rd_code, exp);
    endtask

    task automatic chk_err(input string req, input logic exp);
        #2;
        chk_val(req, "cfg_err", {3'b0, cfg_err}, {3'b0, exp});
    endtask

    task automatic step;
        @(negedge clk);
        cfg_we = 1'b0; dbn_we = 1'b0; line_vld = 1'b0; map_vld = 1'b0; host_we = 1'b0;
    endtask

    task automatic set_src(input logic [1:0] l, input logic [1:0] s);
        @(negedge clk); cfg_we = 1'b1; cfg_link = l; cfg_src = s; step();
    endtask

    task automatic set_dbn(input logic v);
        @(negedge clk); dbn_we = 1'b1; dbn_val = v; step();
    endtask

    task automatic drv_line(input logic [1:0] l, input logic [4:0] c, input logic [3:0] v);
        line_vld = 1'b1; line_link = l; line_ch = c; line_code = v;
    endtask

    task automatic drv_map(input logic [1:0] l, input logic [4:0] c, input logic [3:0] v);
        map_vld = 1'b1; map_link = l; map_ch = c; map_code = v;
    endtask

    task automatic drv_host(input logic [1:0] l, input logic [4:0] c, input logic [3:0] v);
        host_we = 1'b1; host_link = l; host_ch = c; host_code = v;
    endtask

    task automatic line1(input logic [1:0] l, input logic [4:0] c, input logic [3:0] v);
        @(negedge clk); drv_line(l, c, v); step();
    endtask

    task automatic do_reset;
        @(negedge clk); rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        chk_ent("R1", 2'd0, 5'd3, 4'h0);
        chk_ent("R1", 2'd3, 5'd31, 4'h0);
        chk_err("R1", 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            logic [17:0] v;
            v = VEC[i];
            @(negedge clk);
            case (v[17:15])
                OP_CFG:  begin cfg_we = 1'b1; cfg_link = v[14:13]; cfg_src = v[5:4]; step(); end
                OP_LINE: begin drv_line(v[14:13], v[12:8], v[7:4]); step(); end
                OP_MAP:  begin drv_map(v[14:13], v[12:8], v[7:4]); step(); end
                OP_HOST: begin drv_host(v[14:13], v[12:8], v[7:4]); step(); end
                default: chk_ent(rq(int'(v[3:0])), v[14:13], v[12:8], v[7:4]);
            endcase
        end
        // R7: link 2 entered host mode with debounce off
        chk_err("R7", 1'b1);

        // R1: mid-run reset restores defaults; link 1 was mapper, now line
        do_reset();
        chk_ent("R1", 2'd0, 5'd3, 4'h0);
        chk_err("R1", 1'b0);
        line1(2'd1, 5'd4, 4'h8);
        chk_ent("R1", 2'd1, 5'd4, 4'h8);

        // R10: debounce needs two equal codes in a row
        set_dbn(1'b1);
        line1(2'd0, 5'd1, 4'h5);
        chk_ent("R10", 2'd0, 5'd1, 4'h0);
        line1(2'd0, 5'd1, 4'h5);
        chk_ent("R10", 2'd0, 5'd1, 4'h5);
        line1(2'd0, 5'd1, 4'h6);
        line1(2'd0, 5'd1, 4'h7);
        chk_ent("R10", 2'd0, 5'd1, 4'h5);
        line1(2'd0, 5'd1, 4'h7);
        chk_ent("R10", 2'd0, 5'd1, 4'h7);

        // R6: freeze in host mode, host edits, then line resumes
        set_src(2'd0, 2'd2);
        chk_err("R7", 1'b0);
        line1(2'd0, 5'd1, 4'h3);
        line1(2'd0, 5'd1, 4'h3);
        chk_ent("R6", 2'd0, 5'd1, 4'h7);
        chk_ent("R6", 2'd0, 5'd3, 4'h0);
        @(negedge clk); drv_host(2'd0, 5'd1, 4'h9); step();
        chk_ent("R6", 2'd0, 5'd1, 4'h9);
        set_src(2'd0, 2'd0);
        line1(2'd0, 5'd1, 4'h4);
        chk_ent("R10", 2'd0, 5'd1, 4'h9);
        line1(2'd0, 5'd1, 4'h4);
        chk_ent("R6", 2'd0, 5'd1, 4'h4);

        // R10: source change wipes the pending history
        line1(2'd0, 5'd2, 4'hC);
        set_src(2'd0, 2'd2);
        set_src(2'd0, 2'd0);
        line1(2'd0, 5'd2, 4'hC);
        chk_ent("R10", 2'd0, 5'd2, 4'h0);
        line1(2'd0, 5'd2, 4'hC);
        chk_ent("R10", 2'd0, 5'd2, 4'hC);

        // R11: same-entry collision, line mode then host mode
        set_dbn(1'b0);
        @(negedge clk); drv_line(2'd0, 5'd8, 4'h1); drv_host(2'd0, 5'd8, 4'hE); step();
        chk_ent("R11", 2'd0, 5'd8, 4'h1);
        set_src(2'd0, 2'd2);
        chk_err("R7", 1'b1);
        @(negedge clk); drv_line(2'd0, 5'd8, 4'h2); drv_host(2'd0, 5'd8, 4'hE); step();
        chk_ent("R11", 2'd0, 5'd8, 4'hE);

        // R8: three links, three sources, one cycle
        set_src(2'd0, 2'd0);
        set_src(2'd1, 2'd1);
        set_src(2'd2, 2'd2);
        @(negedge clk);
        drv_line(2'd0, 5'd9, 4'h3); drv_map(2'd1, 5'd9, 4'h4); drv_host(2'd2, 5'd9, 4'h5);
        step();
        chk_ent("R8", 2'd0, 5'd9, 4'h3);
        chk_ent("R8", 2'd1, 5'd9, 4'h4);
        chk_ent("R8", 2'd2, 5'd9, 4'h5);
        line1(2'd3, 5'd9, 4'h6);
        chk_ent("R8", 2'd3, 5'd9, 4'h6);
        chk_err("R7", 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule